// File: doc/BRIEF.md
# Segmented Write-Protection Status Controller

This block keeps the protection state of a serial memory's status register and rules on every write request aimed at the memory. A two-bit range code fences off none, the upper quarter, the upper half or all of the array. A sticky lock-enable bit, together with an active-low hardware guard pin, can freeze the status register itself.

The serial front end presents one request per cycle. A request is either a status-register write carrying a data byte, or an array write carrying a 15-bit byte address. The block also sees the current write-enable flag and the guard pin level. One clock later it answers with exactly one accept or reject pulse. An accepted status write raises an update pulse. An accepted array write raises a write-permit pulse.

The status byte is always available for readback. The stored bits come from parameters at power-on reset, which stands in for their nonvolatile nature.

Top module: `wp_status_ctrl`

## Requirements
- R1: Power-on reset loads the range code from `INIT_CODE` and the lock-enable bit from `INIT_LOCK`. No pulse is raised while reset is held.
- R2: `status_out` is laid out as follows: bit 7 is lock-enable, bit 3 is the range code MSB, bit 2 is the range code LSB, and bit 1 follows `we_flag` combinationally. Bits 6, 5, 4 and 0 read 0.
- R3: The range code marks array addresses as protected: 00 none, 01 0x6000–0x7FFF, 10 0x4000–0x7FFF, 11 0x0000–0x7FFF. A lone array write to a protected address is rejected.
- R4: A lone array write to an unprotected address is accepted, with `arr_write_ok` and `req_accept` high for one cycle, only when `we_flag` is 1. Otherwise it is rejected.
- R5: Hardware lock is active exactly when `hw_guard_n` is 0 and the stored lock-enable bit is 1.
- R6: While the hardware lock is active, every status write is rejected and the stored bits stay unchanged. In particular, lock-enable cannot be cleared.
- R7: While the hardware lock is inactive, a lone status write is accepted only when `we_flag` is 1. It then loads data bit 7 into lock-enable and data bits 3:2 into the range code, and ignores the other data bits.
- R8: Each cycle with a request yields exactly one of `req_accept` or `req_reject` in the following cycle. A cycle with no request yields neither.
- R9: A status write and an array write raised in the same cycle give a single reject pulse and change nothing.
- R10: The stored bits hold their values through idle cycles and through changes of `hw_guard_n` and `we_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| we_flag | input | 1 | Current write-enable flag |
| hw_guard_n | input | 1 | Hardware guard pin, low asserts |
| sr_wr_req | input | 1 | Status-register write request |
| sr_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | 15 | Target array byte address |
| sr_update | output | 1 | Status register updated (pulse) |
| arr_write_ok | output | 1 | Array write permitted (pulse) |
| req_accept | output | 1 | Request accepted (pulse) |
| req_reject | output | 1 | Request rejected (pulse) |
| status_out | output | 8 | Status byte for readback |

## Verification
Requests are sampled on a rising edge. The four outcome pulses come from registers loaded on that same edge, so they are due one cycle later and last exactly one cycle. The stored bits in `status_out` also change on that edge, while its write-enable bit follows `we_flag` without delay. The bench drives each request on a falling edge and samples every output on the next falling edge, where both the pulses and the new status byte have settled. It then drops the request before the following edge, so the next sample also shows the quiet state.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] rng_code;
  } prot_bits_t;

  localparam int LOCK_BIT = 7;
  localparam int CODE_HI  = 3;
  localparam int CODE_LO  = 2;
  localparam int WE_BIT   = 1;

  function automatic logic [7:0] pack_status(prot_bits_t p, logic we);
    logic [7:0] s;
    s           = '0;
    s[LOCK_BIT] = p.lock_en;
    s[CODE_HI]  = p.rng_code[1];
    s[CODE_LO]  = p.rng_code[0];
    s[WE_BIT]   = we;
    return s;
  endfunction

  function automatic prot_bits_t unpack_write(logic [7:0] d);
    prot_bits_t p;
    p.lock_en  = d[LOCK_BIT];
    p.rng_code = d[CODE_HI:CODE_LO];
    return p;
  endfunction

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        code,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (code)
      2'b00:   hit = 1'b0;
      2'b01:   hit = addr[TOP] & addr[TOP-1];
      2'b10:   hit = addr[TOP];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_hw_qual.sv
module wp_hw_qual (
  input  logic guard_n,
  input  logic lock_en,
  output logic hw_lock
);
  assign hw_lock = ~guard_n & lock_en;
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_pkg::*;
#(
  parameter logic [1:0] INIT_CODE = 2'b00,
  parameter logic       INIT_LOCK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  prot_bits_t din,
  output prot_bits_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.lock_en  <= INIT_LOCK;
      q.rng_code <= INIT_CODE;
    end else if (load) begin
      q <= din;
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R10
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_pkg::*;
#(
  parameter int         ADDR_W    = 15,
  parameter logic [1:0] INIT_CODE = 2'b00,
  parameter logic       INIT_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_flag,
  input  logic              hw_guard_n,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              sr_update,
  output logic              arr_write_ok,
  output logic              req_accept,
  output logic              req_reject,
  output logic [7:0]        status_out
);
  prot_bits_t prot_q;
  logic range_hit, hw_lock;
  logic any_req, lone_sr, lone_arr, sr_grant, arr_grant, grant;

  wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
    .addr(arr_addr), .code(prot_q.rng_code), .hit(range_hit)
  );

  wp_hw_qual u_qual (
    .guard_n(hw_guard_n), .lock_en(prot_q.lock_en), .hw_lock(hw_lock)
  );

  wp_status_regs #(.INIT_CODE(INIT_CODE), .INIT_LOCK(INIT_LOCK)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(sr_grant),
    .din(unpack_write(sr_wr_data)), .q(prot_q)
  );

  assign any_req   = sr_wr_req | arr_wr_req;
  assign lone_sr   = sr_wr_req & ~arr_wr_req;
  assign lone_arr  = arr_wr_req & ~sr_wr_req;
  assign sr_grant  = lone_sr & we_flag & ~hw_lock;
  assign arr_grant = lone_arr & we_flag & ~range_hit;
  assign grant     = sr_grant | arr_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_update    <= 1'b0;
      arr_write_ok <= 1'b0;
      req_accept   <= 1'b0;
      req_reject   <= 1'b0;
    end else begin
      sr_update    <= sr_grant;
      arr_write_ok <= arr_grant;
      req_accept   <= grant;
      req_reject   <= any_req & ~grant;
    end
  end

  assign status_out = pack_status(prot_q, we_flag);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> $countones({req_accept, req_reject}) == 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !req_accept && !req_reject); // R8
  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_req && range_hit |=> !arr_write_ok && req_reject); // R3
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_req && hw_lock |=> $stable(prot_q) && !sr_update); // R6
  AST_NO_WE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    any_req && !we_flag |=> req_reject); // R4
  AST_DUAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_req && arr_wr_req |=> req_reject && $stable(prot_q)); // R9
endmodule

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         AW         = 15;
  localparam logic [1:0] P_CODE     = 2'b01;
  localparam logic       P_LOCK     = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we_flag = 1'b0, hw_guard_n = 1'b0;
  logic sr_wr_req = 1'b0, arr_wr_req = 1'b0;
  logic [7:0] sr_wr_data = '0;
  logic [AW-1:0] arr_addr = '0;
  logic sr_update, arr_write_ok, req_accept, req_reject;
  logic [7:0] status_out;

  int n_vec = 0, n_bad = 0;
  int m_code, m_lock;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_ctrl #(.ADDR_W(AW), .INIT_CODE(P_CODE), .INIT_LOCK(P_LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .we_flag(we_flag), .hw_guard_n(hw_guard_n),
    .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .arr_wr_req(arr_wr_req),
    .arr_addr(arr_addr), .sr_update(sr_update), .arr_write_ok(arr_write_ok),
    .req_accept(req_accept), .req_reject(req_reject), .status_out(status_out)
  );

  function automatic int low_bound(int code);
    case (code)
      0: return 32768;
      1: return 24576;
      2: return 16384;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(int we);
    return 8'(m_lock * 128 + m_code * 4 + we * 2);
  endfunction

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got upd/ok/acc/rej/status=%b exp %b", tag, act, exp);
    end
  endtask

  task automatic apply(input bit s, input bit a, input logic [7:0] d, input int ad,
                       input int w, input int g, input string tag);
    bit hw, sok, aok, acc, rej, prot;
    @(negedge clk);
    sr_wr_req = s; arr_wr_req = a; sr_wr_data = d; arr_addr = AW'(ad);
    we_flag = w[0]; hw_guard_n = g[0];
    hw   = (g == 0) && (m_lock == 1);
    prot = ad >= low_bound(m_code);
    sok  = s && !a && !hw && (w == 1);
    aok  = a && !s && (w == 1) && !prot;
    acc  = sok || aok;
    rej  = (s || a) && !acc;
    if (sok) begin
      m_code = int'(d[3:2]);
      m_lock = int'(d[7]);
    end
    @(negedge clk);
    check({sr_update, arr_write_ok, req_accept, req_reject, status_out},
          {sok, aok, acc, rej, exp_status(w)}, tag);
    sr_wr_req = 1'b0; arr_wr_req = 1'b0;
  endtask

  task automatic idle(input int w, input int g, input string tag);
    @(negedge clk);
    we_flag = w[0]; hw_guard_n = g[0];
    @(negedge clk);
    check({sr_update, arr_write_ok, req_accept, req_reject, status_out},
          {4'b0000, exp_status(w)}, tag);
  endtask

  initial begin
    m_code = int'(P_CODE);
    m_lock = int'(P_LOCK);
    repeat (3) @(negedge clk);
    check({sr_update, arr_write_ok, req_accept, req_reject, status_out},
          {4'b0000, 8'h84}, "R1 during reset");
    rst_n = 1'b1;
    idle(0, 0, "R1 after reset");
    idle(1, 0, "R2 we bit live");
    // lock active from reset: clearing attempt must fail
    apply(1, 0, 8'h00, 0, 1, 0, "R6 lock held at reset");
    apply(1, 0, 8'h00, 0, 1, 1, "R5 guard high releases");
    apply(1, 0, 8'h7B, 0, 1, 1, "R7 ignored bits");
    idle(1, 0, "R2 status layout");
    for (int code = 0; code < 4; code++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int g = 0; g < 2; g++) begin
          for (int w = 0; w < 2; w++) begin
            apply(1, 0, 8'(lk * 128 + code * 4 + 8'h33), 0, 1, 1, "R7 program");
            idle(w, g, "R10 hold");
            for (int i = 0; i < 128; i++)
              apply(0, 1, 8'h00, i * 256 + ((i * 37) % 256), w, g, "R4/R3 sweep");
            apply(0, 1, 8'h00, 16'h5FFF, w, g, "R3 boundary");
            apply(0, 1, 8'h00, 16'h6000, w, g, "R3 boundary");
            apply(0, 1, 8'h00, 16'h3FFF, w, g, "R3 boundary");
            apply(0, 1, 8'h00, 16'h4000, w, g, "R3 boundary");
            apply(0, 1, 8'h00, 16'h7FFF, w, g, "R3 boundary");
            apply(1, 1, 8'h8C, 16'h0000, w, g, "R9 dual request");
            idle(w, g, "R8 quiet");
            apply(1, 0, 8'(((lk ^ 1) * 128) + ((3 - code) * 4)), 0, w, g, "R5/R6/R7 status write");
            idle(w, 1 - g, "R10 pin change");
          end
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule